// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frame bytes into memory under the control of a ring of descriptors that software prepares. Each descriptor occupies eight 32-bit words. Word 0 holds the ownership flag and later the write-back status. Word 1 holds the two buffer sizes and the end-of-ring marker. Words 2 and 3 hold the two buffer start addresses. The remaining words are not touched. The engine fetches the descriptor at its current pointer and checks that hardware owns it. It then stores the incoming bytes of one frame, first into buffer 1 and then into buffer 2. At the end of the frame it writes a status word that returns the descriptor to software and moves on to the next entry.

Software sets `run` and supplies the ring base address. It fills descriptors and sets their ownership bits, and it pulses `poll` after it has handed a descriptor back to hardware. While the engine is parked on a descriptor that software owns, it drops incoming bytes. The engine accepts stream bytes only while `rx_ready` is high. The memory port is word addressed with byte enables, and read data returns one cycle after the request.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, and while `run` is low, the engine makes no memory request and holds `rx_ready` low.
- R2: The engine reads the descriptor's word 0. If bit 31 of that word is clear, the engine suspends: it keeps `rx_ready` low, makes no memory write and drops stream bytes.
- R3: A one-cycle `poll` pulse while the engine is suspended makes it read word 0 of the same descriptor again.
- R4: Byte i of a frame is written to buffer-1 address plus i, as a single-byte write. The request carries the word-aligned address, the byte enable `1 << addr[1:0]`, and the byte replicated in all four lanes.
- R5: Word 1 bits 12:0 give the buffer-1 size and bits 28:16 give the buffer-2 size. Once buffer 1 is full, byte i goes to buffer-2 address plus (i - size1).
- R6: Each buffer size is limited to 8184 bytes. A larger size field is treated as 8184.
- R7: Bytes beyond size1 + size2 are not written. The write-back then sets bit 11 (overflow).
- R8: At frame end the engine writes word 0 with all four byte enables set. The written word has bit 31 clear, the stored byte count in bits 29:16, and bits 9 and 8 set (first and last segment). Bit 3 is set if any byte of the frame carried `s_err`. Bit 15 is the OR of bits 11 and 3; all other bits are zero.
- R9: After the write-back the pointer advances by 32 bytes. If word 1 bit 15 is set, the pointer returns to the ring base instead.
- R10: Dropping `run` returns the pointer to the ring base, so the next start fetches entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Engine enable level |
| poll | input | 1 | Poll-demand strobe |
| ring_base | input | 32 | Byte address of ring entry 0 |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of frame |
| s_err | input | 1 | Receive error flag for this byte |
| rx_ready | output | 1 | Engine holds an owned descriptor and accepts bytes |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The assertions assume that memory read data arrives exactly one cycle after a read request. They also assume that `poll` and `run` are sampled as plain levels, with no ordering against the stream. They treat stream bytes that arrive while `rx_ready` is low as legitimately discarded. The stimulus sends a frame only after it has seen `rx_ready` high. It rewrites descriptor words only while the engine is suspended or stopped, so the engine never fetches a descriptor that is half written. The bench memory model answers every read with a fixed one-cycle latency.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int MAX_BUF = 8184,
  parameter int LEN_W   = 14,
  parameter int DESC_B  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        poll,
  input  logic [31:0] ring_base,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  input  logic        s_err,
  output logic        rx_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam logic [12:0] MAXC = 13'(MAX_BUF);

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_FCAP, ST_SUSP, ST_RECV, ST_WB} st_t;
  st_t st;

  logic [31:0] ptr, size_w, a1, a2;
  logic [1:0]  fidx;
  logic [LEN_W-1:0] cnt;
  logic ovf, rerr;

  wire [12:0] b1c = (size_w[12:0] > MAXC) ? MAXC : size_w[12:0];
  wire [12:0] b2c = (size_w[28:16] > MAXC) ? MAXC : size_w[28:16];
  wire [LEN_W-1:0] cap = LEN_W'(b1c) + LEN_W'(b2c);
  wire room = cnt < cap;
  wire in1  = cnt < LEN_W'(b1c);
  wire [LEN_W-1:0] off2 = cnt - LEN_W'(b1c);
  wire [31:0] baddr = in1 ? a1 + 32'(cnt) : a2 + 32'(off2);
  wire byte_wr = (st == ST_RECV) && s_valid && room;
  wire es = ovf | rerr;
  wire [31:0] status = {2'b00, cnt, es, 3'b000, ovf, 1'b0, 2'b11, 4'b0000, rerr, 3'b000};

  assign rx_ready  = (st == ST_RECV);
  assign mem_req   = (st == ST_FETCH) || (st == ST_WB) || byte_wr;
  assign mem_we    = (st == ST_WB) || byte_wr;
  assign mem_addr  = (st == ST_FETCH) ? ptr + {28'd0, fidx, 2'b00} :
                     (st == ST_WB)    ? ptr : {baddr[31:2], 2'b00};
  assign mem_be    = (st == ST_WB) ? 4'hF : (4'b0001 << baddr[1:0]);
  assign mem_wdata = (st == ST_WB) ? status : {4{s_data}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ptr <= '0; size_w <= '0; a1 <= '0; a2 <= '0;
      fidx <= '0; cnt <= '0; ovf <= 1'b0; rerr <= 1'b0;
    end else if (!run) begin
      st <= ST_IDLE; ptr <= ring_base;
    end else begin
      case (st)
        ST_IDLE: begin st <= ST_FETCH; fidx <= 2'd0; ptr <= ring_base; end
        ST_FETCH: st <= ST_FCAP;
        ST_FCAP: begin
          case (fidx)
            2'd0: st <= mem_rdata[31] ? ST_FETCH : ST_SUSP;
            2'd1: begin size_w <= mem_rdata; st <= ST_FETCH; end
            2'd2: begin a1 <= mem_rdata; st <= ST_FETCH; end
            default: begin
              a2 <= mem_rdata; st <= ST_RECV;
              cnt <= '0; ovf <= 1'b0; rerr <= 1'b0;
            end
          endcase
          fidx <= fidx + 2'd1;
        end
        ST_SUSP: if (poll) begin st <= ST_FETCH; fidx <= 2'd0; end
        ST_RECV: if (s_valid) begin
          if (room) cnt <= cnt + 1'b1;
          else      ovf <= 1'b1;
          if (s_err) rerr <= 1'b1;
          if (s_last) st <= ST_WB;
        end
        ST_WB: begin
          ptr  <= size_w[15] ? ring_base : ptr + 32'(DESC_B);
          st   <= ST_FETCH;
          fidx <= 2'd0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!mem_req && !rx_ready));
  assert_susp_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP) |-> (!mem_we && !rx_ready));
  assert_poll_refetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && poll && run) |=> (mem_req && !mem_we && mem_addr == $past(ptr)));
  assert_byte_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && rx_ready) |-> ($countones(mem_be) == 1 && mem_wdata[7:0] == mem_wdata[31:24]));
  assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && s_valid && run && !room) |=> ovf);
  assert_handback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == 4'hF) |-> (!mem_wdata[31] && mem_wdata[15] == (mem_wdata[11] | mem_wdata[3])));
  assert_ring_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB && run) |=> (ptr == $past(ptr) + 32'(DESC_B) || ptr == $past(ring_base)));
endmodule

// File: tb/test_rx_ring_dma.sv
`timescale 1ns/1ps
module test_rx_ring_dma;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, run, poll, s_valid, s_last, s_err;
  logic [31:0] ring_base;
  logic [7:0]  s_data;
  logic rx_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  rx_ring_dma i_rx_ring_dma (
    .clk(clk), .rst_n(rst_n), .run(run), .poll(poll), .ring_base(ring_base),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_err(s_err),
    .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [31:0] mem [int];
  logic [31:0] mw;
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mw = mem.exists(int'(mem_addr >> 2)) ? mem[int'(mem_addr >> 2)] : 32'h0;
        for (int b = 0; b < 4; b++) if (mem_be[b]) mw[8*b +: 8] = mem_wdata[8*b +: 8];
        mem[int'(mem_addr >> 2)] = mw;
      end else begin
        mem_rdata <= mem.exists(int'(mem_addr >> 2)) ? mem[int'(mem_addr >> 2)] : 32'h0;
      end
    end
  end

  int n_chk = 0, n_fail = 0, n_wr = 0;
  task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed { logic [31:0] a; logic [3:0] be; logic [31:0] d; } wr_t;
  wr_t expq[$];
  string tagq[$];

  always @(negedge clk) begin
    #1;
    if (rst_n && mem_req && mem_we) begin
      n_wr++;
      if (expq.size() == 0) chk("R2 unexpected write", {mem_addr, mem_be, mem_wdata}, 68'h0);
      else begin
        wr_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(t, {mem_addr, mem_be, mem_wdata}, e);
      end
    end
  end

  task automatic set_desc(input int idx, input bit own, input logic [31:0] sz,
                          input logic [31:0] b1a, input logic [31:0] b2a);
    int w;
    w = int'((BASE + 32'(idx * 32)) >> 2);
    mem[w] = {own, 31'd0}; mem[w+1] = sz; mem[w+2] = b1a; mem[w+3] = b2a;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_poll;
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_ready(input string tag);
    int k;
    k = 0;
    while (!rx_ready && k < 200) begin @(negedge clk); k++; end
    chk(tag, 68'(rx_ready), 68'd1);
  endtask

  task automatic send_frame(input int idx, input int n, input bit err,
                            input logic [31:0] sz, input logic [31:0] b1a,
                            input logic [31:0] b2a, input int seed, input string tag);
    int b1c, b2c, stored;
    logic [31:0] a, st;
    logic [7:0] d;
    b1c = (sz[12:0] > 13'd8184) ? 8184 : int'(sz[12:0]);
    b2c = (sz[28:16] > 13'd8184) ? 8184 : int'(sz[28:16]);
    stored = 0;
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 7);
      if (i < b1c + b2c) begin
        a = (i < b1c) ? b1a + 32'(i) : b2a + 32'(i - b1c);
        expq.push_back({a[31:2], 2'b00, 4'b0001 << a[1:0], {4{d}}});
        tagq.push_back(tag);
        stored++;
      end
    end
    st = {2'b00, 14'(stored), (n > b1c + b2c) || err, 3'b000, n > b1c + b2c,
          1'b0, 2'b11, 4'b0000, err, 3'b000};
    expq.push_back({BASE + 32'(idx * 32), 4'hF, st});
    tagq.push_back({tag, " R8 status"});
    wait_ready({tag, " ready"});
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = 8'(seed + i * 7);
      s_last = (i == n - 1); s_err = err && (i == n - 1);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
    for (int k = 0; k < 50 && expq.size() != 0; k++) @(negedge clk);
    chk({tag, " all writes seen"}, 68'(expq.size()), 68'd0);
    expq.delete(); tagq.delete();
    cycles(12);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int wr0;
  initial begin
    rst_n = 1'b0; run = 1'b0; poll = 1'b0; ring_base = BASE;
    s_valid = 1'b0; s_data = 8'h0; s_last = 1'b0; s_err = 1'b0;
    set_desc(0, 1'b0, 32'd16, 32'h1001, 32'h0);
    set_desc(1, 1'b1, 32'd4 | (32'd8 << 16), 32'h1100, 32'h1203);
    set_desc(2, 1'b1, 32'd3 | (32'd2 << 16), 32'h1400, 32'h1500);
    set_desc(3, 1'b1, 32'd8 | 32'h8000, 32'h1600, 32'h0);
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    chk("R1 reset rx_ready", 68'(rx_ready), 68'd0);
    chk("R1 reset no request", 68'(mem_req), 68'd0);

    @(negedge clk); run = 1'b1;
    cycles(20);
    chk("R2 software-owned suspends", 68'(rx_ready), 68'd0);
    wr0 = n_wr;
    for (int i = 0; i < 4; i++) begin
      s_valid = 1'b1; s_data = 8'(i); s_last = (i == 3); @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
    cycles(5);
    chk("R2 bytes dropped, no write", 68'(n_wr - wr0), 68'd0);

    set_desc(0, 1'b1, 32'd16, 32'h1001, 32'h0);
    pulse_poll();
    send_frame(0, 10, 1'b0, 32'd16, 32'h1001, 32'h0, 3, "R3 R4 poll then frame A");
    send_frame(1, 9, 1'b1, 32'd4 | (32'd8 << 16), 32'h1100, 32'h1203, 40, "R5 spill frame B");
    send_frame(2, 7, 1'b0, 32'd3 | (32'd2 << 16), 32'h1400, 32'h1500, 90, "R7 overflow frame C");
    send_frame(3, 2, 1'b0, 32'd8 | 32'h8000, 32'h1600, 32'h0, 17, "R9 last entry D");

    cycles(10);
    chk("R9 wrapped to handed-back entry 0", 68'(rx_ready), 68'd0);
    set_desc(0, 1'b1, 32'd6, 32'h1700, 32'h0);
    pulse_poll();
    send_frame(0, 6, 1'b0, 32'd6, 32'h1700, 32'h0, 55, "R9 wrap frame E exact fit");

    cycles(10);
    chk("R2 entry 1 handed back", 68'(rx_ready), 68'd0);
    set_desc(1, 1'b1, 32'h1FFF | (32'd4 << 16), 32'h4000, 32'h8001);
    pulse_poll();
    send_frame(1, 8186, 1'b0, 32'h1FFF | (32'd4 << 16), 32'h4000, 32'h8001, 11, "R6 clamp frame F");

    cycles(10);
    chk("R2 entry 2 suspended", 68'(rx_ready), 68'd0);
    @(negedge clk); run = 1'b0;
    cycles(3);
    chk("R10 stopped rx_ready", 68'(rx_ready), 68'd0);
    chk("R10 stopped no request", 68'(mem_req), 68'd0);
    set_desc(0, 1'b1, 32'd8, 32'h1800, 32'h0);
    @(negedge clk); run = 1'b1;
    send_frame(0, 3, 1'b0, 32'd8, 32'h1800, 32'h0, 200, "R10 restart at entry 0 frame G");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule